// File: doc/BRIEF.md
# Register List Stack Frame Sequencer

This block carries out the memory traffic of a function's entry and exit frame. On entry (the prepare operation) it saves any subset of the twelve callee-saved registers r20 to r31 to the stack, one word per selected register, and then lowers the stack pointer further to make room for the function's locals. On exit (the dispose operation) it first gives back the local area, then reloads the saved registers from the stack in the mirror order. It can also hand back a jump target read from a chosen general register once the reloads are done.

A caller pulses `start_i` while the block is idle. With the pulse it gives the operation, a 12-bit register selection mask, a 5-bit frame size in words, a 5-bit jump register index and the current stack pointer. The block then drives a register file port and a word-wide memory port with a ready handshake. It reports the final stack pointer and an optional jump target along with a one-cycle done pulse.

The control is a five-state machine. IDLE waits for a start. A start goes to PUSH (prepare, non-empty mask), to POP (dispose, non-empty mask), to JUMP (dispose, empty mask, nonzero jump index) or straight to FIN. PUSH stays in PUSH until the last selected register is stored, then goes to FIN. POP stays in POP until the last selected register is loaded, then goes to JUMP if the jump index is nonzero and to FIN otherwise. JUMP always goes to FIN, and FIN always goes back to IDLE.

Top module: `stack_frame_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `mem_req_o`, `rf_we_o` and `jump_o` are all low.
- R2: Mask bit k (k = 0..11) selects register r(20+k). Prepare stores the selected registers in ascending register number. Before each store it lowers the stack pointer by 4 and stores the register value at the new pointer, so r20 ends up at the highest address.
- R3: Once every selected register is stored, prepare lowers the stack pointer again by 4 times the frame size. The final `sp_o` is the start pointer minus 4 per selected register minus 4 times the frame size.
- R4: Dispose first raises the stack pointer by 4 times the frame size. It then loads the selected registers in descending register number (r31 first), each from the current pointer, and raises the pointer by 4 after each load.
- R5: If the dispose jump index is nonzero, `jump_o` is high in the done cycle and `jump_addr_o` holds the value of that register read after all loads. With a zero index, `jump_o` stays low.
- R6: Unselected mask bits take no memory cycles. The number of memory accesses equals the number of set mask bits. With zero wait states, done comes n+1 cycles after the start edge, plus one cycle when a dispose jumps. An empty mask with no jump finishes in one cycle.
- R7: A memory access completes only in a cycle where `mem_rdy_i` is high. While it waits, the request, address and direction stay unchanged.
- R8: `busy_o` is high from the cycle after the start edge through the done cycle. `done_o` is a one-cycle pulse, and the cycle after it is idle.
- R9: A `start_i` pulse while `busy_o` is high is ignored. It changes neither the running sequence nor anything after it.
- R10: `op_i` = 0 selects prepare and `op_i` = 1 selects dispose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, taken only while idle |
| op_i | input | 1 | 0 = prepare, 1 = dispose |
| list_i | input | 12 | Register selection mask, bit k selects r(20+k) |
| frame_i | input | 5 | Local frame size in words |
| jreg_i | input | 5 | Dispose jump register index, 0 = no jump |
| sp_i | input | 32 | Stack pointer at start |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | 32 | Working stack pointer, final value at done |
| rf_idx_o | output | 5 | Register file index for read or write |
| rf_rdata_i | input | 32 | Register file read data for `rf_idx_o` |
| rf_we_o | output | 1 | Register file write enable |
| rf_wdata_o | output | 32 | Register file write data |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = store, 0 = load |
| mem_addr_o | output | 32 | Byte address of the word access |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Load data |
| mem_rdy_i | input | 1 | Access completes in this cycle |
| jump_o | output | 1 | Jump target valid, with done |
| jump_addr_o | output | 32 | Jump target from the named register |

## Verification
A wrong pending mask or state shows at the memory port in the very next access. The symptom is an extra or missing request, a store of the wrong register, or an address that is not 4 below the pointer. It also moves the done cycle away from its exact count. A wrong stack pointer update shows one access later as a shifted address, and always as a wrong `sp_o` at done. The bench compares memory contents, reloaded registers, final pointer, access count and exact cycle count against values derived from the mask, frame size and wait-state setting. Checkers also watch the handshake hold, the address rule and the pointer step on every cycle.

// File: rtl/stack_frame_pkg.sv
package stack_frame_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH,
        S_POP,
        S_JUMP,
        S_FIN
    } seq_state_t;

    localparam logic OP_PREPARE = 1'b0;
    localparam logic OP_DISPOSE = 1'b1;

endpackage

// File: rtl/frame_list_picker.sv
module frame_list_picker #(
    parameter int LIST_W = 12,
    parameter int SEL_W  = $clog2(LIST_W)
) (
    input  logic [LIST_W-1:0] pend_i,
    input  logic              desc_i,
    output logic [SEL_W-1:0]  sel_o,
    output logic              last_o
);

    logic [SEL_W-1:0]  lo_idx;
    logic [SEL_W-1:0]  hi_idx;
    logic [LIST_W-1:0] remain;

    always_comb begin
        lo_idx = '0;
        for (int k = LIST_W - 1; k >= 0; k--) begin
            if (pend_i[k]) lo_idx = k[SEL_W-1:0];
        end
    end

    always_comb begin
        hi_idx = '0;
        for (int k = 0; k < LIST_W; k++) begin
            if (pend_i[k]) hi_idx = k[SEL_W-1:0];
        end
    end

    assign sel_o  = desc_i ? hi_idx : lo_idx;
    assign remain = pend_i & ~(LIST_W'(1) << sel_o);
    assign last_o = (|pend_i) && (remain == '0);

endmodule

// File: rtl/frame_bytes.sv
module frame_bytes #(
    parameter int FRAME_W = 5,
    parameter int AW      = 32,
    parameter int SHIFT   = 2
) (
    input  logic [FRAME_W-1:0] frame_i,
    output logic [AW-1:0]      bytes_o
);

    assign bytes_o = AW'(frame_i) << SHIFT;

endmodule

// File: rtl/stack_frame_seq.sv
module stack_frame_seq
    import stack_frame_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int LIST_W     = 12,
    parameter int FRAME_W    = 5,
    parameter int RIDX_W     = 5,
    parameter int BASE_REG   = 20,
    parameter int WORD_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               op_i,
    input  logic [LIST_W-1:0]  list_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [RIDX_W-1:0]  jreg_i,
    input  logic [AW-1:0]      sp_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [AW-1:0]      sp_o,
    output logic [RIDX_W-1:0]  rf_idx_o,
    input  logic [DW-1:0]      rf_rdata_i,
    output logic               rf_we_o,
    output logic [DW-1:0]      rf_wdata_o,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic [AW-1:0]      mem_addr_o,
    output logic [DW-1:0]      mem_wdata_o,
    input  logic [DW-1:0]      mem_rdata_i,
    input  logic               mem_rdy_i,
    output logic               jump_o,
    output logic [AW-1:0]      jump_addr_o
);

    localparam int                SEL_W     = $clog2(LIST_W);
    localparam int                SHIFT     = $clog2(WORD_BYTES);
    localparam logic [AW-1:0]     WORD_STEP = AW'(WORD_BYTES);
    localparam logic [RIDX_W-1:0] BASE_IDX  = RIDX_W'(BASE_REG);

    seq_state_t         state_q, state_d;
    logic [LIST_W-1:0]  pend_q;
    logic               op_q;
    logic [RIDX_W-1:0]  jreg_q;
    logic [FRAME_W-1:0] frame_q;
    logic [AW-1:0]      sp_q;
    logic [AW-1:0]      jaddr_q;
    logic               jmp_q;

    logic [AW-1:0]      fb_start;
    logic [AW-1:0]      fb_held;
    logic [SEL_W-1:0]   sel;
    logic               last;
    logic [LIST_W-1:0]  sel_mask;
    logic               acc_done;
    logic               start_ok;

    frame_list_picker #(
        .LIST_W (LIST_W),
        .SEL_W  (SEL_W)
    ) u_pick (
        .pend_i (pend_q),
        .desc_i (op_q == OP_DISPOSE),
        .sel_o  (sel),
        .last_o (last)
    );

    frame_bytes #(
        .FRAME_W (FRAME_W),
        .AW      (AW),
        .SHIFT   (SHIFT)
    ) u_fb_start (
        .frame_i (frame_i),
        .bytes_o (fb_start)
    );

    frame_bytes #(
        .FRAME_W (FRAME_W),
        .AW      (AW),
        .SHIFT   (SHIFT)
    ) u_fb_held (
        .frame_i (frame_q),
        .bytes_o (fb_held)
    );

    assign sel_mask = LIST_W'(1) << sel;
    assign acc_done = mem_rdy_i && ((state_q == S_PUSH) || (state_q == S_POP));
    assign start_ok = start_i && (state_q == S_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    if (|list_i)
                        state_d = (op_i == OP_DISPOSE) ? S_POP : S_PUSH;
                    else if ((op_i == OP_DISPOSE) && (|jreg_i))
                        state_d = S_JUMP;
                    else
                        state_d = S_FIN;
                end
            end
            S_PUSH: begin
                if (mem_rdy_i && last) state_d = S_FIN;
            end
            S_POP: begin
                if (mem_rdy_i && last) state_d = (|jreg_q) ? S_JUMP : S_FIN;
            end
            S_JUMP:  state_d = S_FIN;
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            op_q    <= OP_PREPARE;
            jreg_q  <= '0;
            frame_q <= '0;
            sp_q    <= '0;
            jaddr_q <= '0;
            jmp_q   <= 1'b0;
        end else begin
            if (start_ok) begin
                pend_q  <= list_i;
                op_q    <= op_i;
                jreg_q  <= jreg_i;
                frame_q <= frame_i;
                jmp_q   <= 1'b0;
                if (op_i == OP_DISPOSE)
                    sp_q <= sp_i + fb_start;
                else if (list_i == '0)
                    sp_q <= sp_i - fb_start;
                else
                    sp_q <= sp_i;
            end else if (acc_done) begin
                pend_q <= pend_q & ~sel_mask;
                if (state_q == S_PUSH)
                    sp_q <= last ? (sp_q - WORD_STEP - fb_held) : (sp_q - WORD_STEP);
                else
                    sp_q <= sp_q + WORD_STEP;
            end else if (state_q == S_JUMP) begin
                jaddr_q <= AW'(rf_rdata_i);
                jmp_q   <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy_o      = (state_q != S_IDLE);
        done_o      = (state_q == S_FIN);
        jump_o      = (state_q == S_FIN) && jmp_q;
        jump_addr_o = jaddr_q;
        sp_o        = sp_q;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = sp_q;
        mem_wdata_o = rf_rdata_i;
        rf_idx_o    = '0;
        rf_we_o     = 1'b0;
        rf_wdata_o  = mem_rdata_i;
        unique case (state_q)
            S_PUSH: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = sp_q - WORD_STEP;
                rf_idx_o   = BASE_IDX + RIDX_W'(sel);
            end
            S_POP: begin
                mem_req_o = 1'b1;
                rf_idx_o  = BASE_IDX + RIDX_W'(sel);
                rf_we_o   = mem_rdy_i;
            end
            S_JUMP:  rf_idx_o = jreg_q;
            default: ;
        endcase
    end

endmodule

// File: rtl/stack_frame_seq_chk.sv
module stack_frame_seq_chk #(
    parameter int AW     = 32,
    parameter int RIDX_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic              mem_rdy_i,
    input logic [AW-1:0]     mem_addr_o,
    input logic [AW-1:0]     sp_o,
    input logic              rf_we_o,
    input logic [RIDX_W-1:0] rf_idx_o,
    input logic              jump_o
);

    p_req_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> busy_o);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    p_hold_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    p_push_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> (mem_addr_o == sp_o - AW'(4)));

    p_pop_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o && mem_rdy_i) |=> (sp_o == $past(sp_o) + AW'(4)));

    p_load_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> (mem_req_o && !mem_we_o && mem_rdy_i));

    p_reg_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> ((rf_idx_o >= RIDX_W'(20)) && (rf_idx_o <= RIDX_W'(31))));

    p_jump_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        jump_o |-> done_o);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(sp_o));

endmodule

bind stack_frame_seq stack_frame_seq_chk #(.AW(AW), .RIDX_W(RIDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_rdy_i  (mem_rdy_i),
    .mem_addr_o (mem_addr_o),
    .sp_o       (sp_o),
    .rf_we_o    (rf_we_o),
    .rf_idx_o   (rf_idx_o),
    .jump_o     (jump_o)
);

// File: tb/stack_frame_seq_bench.sv
module stack_frame_seq_bench;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, start_i, op_i;
    logic [11:0] list_i;
    logic [4:0]  frame_i, jreg_i;
    logic [31:0] sp_i;
    logic        busy_o, done_o, rf_we_o, mem_req_o, mem_we_o, mem_rdy_i, jump_o;
    logic [31:0] sp_o, rf_rdata_i, rf_wdata_o, mem_addr_o, mem_wdata_o, mem_rdata_i, jump_addr_o;
    logic [4:0]  rf_idx_o;

    int checks = 0;
    int fails  = 0;
    int wait_cfg = 0;
    int wcnt = 0;
    int acc_cnt = 0;

    logic [31:0] regs [32];
    logic [31:0] mem  [256];
    logic [31:0] regsnap [32];
    logic [31:0] memsnap [256];

    stack_frame_seq u_stack_frame_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .list_i(list_i),
        .frame_i(frame_i), .jreg_i(jreg_i), .sp_i(sp_i), .busy_o(busy_o), .done_o(done_o),
        .sp_o(sp_o), .rf_idx_o(rf_idx_o), .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o),
        .rf_wdata_o(rf_wdata_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .mem_rdy_i(mem_rdy_i), .jump_o(jump_o), .jump_addr_o(jump_addr_o)
    );

    assign rf_rdata_i  = regs[rf_idx_o];
    assign mem_rdata_i = mem[mem_addr_o[9:2]];
    assign mem_rdy_i   = mem_req_o && (wcnt >= wait_cfg);

    always @(posedge clk) begin
        if (mem_req_o && !mem_rdy_i) wcnt <= wcnt + 1;
        else                         wcnt <= 0;
        if (mem_req_o && mem_rdy_i) begin
            acc_cnt <= acc_cnt + 1;
            if (mem_we_o) mem[mem_addr_o[9:2]] <= mem_wdata_o;
        end
        if (rf_we_o) regs[rf_idx_o] <= rf_wdata_o;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    // one operation; poke > 0 pulses start with other inputs in that cycle
    task automatic run_op(input logic op, input logic [11:0] list, input logic [4:0] frame,
                          input logic [4:0] jreg, input logic [31:0] sp, input int poke,
                          output int cyc);
        @(negedge clk);
        start_i = 1'b1; op_i = op; list_i = list; frame_i = frame; jreg_i = jreg; sp_i = sp;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (cyc == poke) begin
                start_i = 1'b1; op_i = ~op; list_i = 12'h0F0; frame_i = 5'd9; sp_i = 32'h100;
            end else begin
                start_i = 1'b0;
            end
        end while (!done_o && cyc < 5000);
        start_i = 1'b0;
        if (cyc >= 5000) chk(1'b0, "R8 done never seen", 32'(cyc), 32'd0);
    endtask

    task automatic after_done(input string tag);
        @(negedge clk);
        chk(!done_o && !busy_o, {"R8 idle after done ", tag}, {30'd0, done_o, busy_o}, 32'd0);
    endtask

    function automatic int popc(input logic [11:0] v);
        int n = 0;
        for (int k = 0; k < 12; k++) n += int'(v[k]);
        return n;
    endfunction

    task automatic prepare_test(input logic [11:0] list, input logic [4:0] frame,
                                input logic [31:0] sp, input int w, input int poke,
                                input string tag);
        int cyc;
        int a0;
        int n;
        logic [31:0] addr;
        wait_cfg = w;
        regsnap = regs;
        a0 = acc_cnt;
        n = popc(list);
        run_op(1'b0, list, frame, 5'd0, sp, poke, cyc);
        addr = sp;
        for (int k = 0; k < 12; k++) begin
            if (list[k]) begin
                addr = addr - 32'd4;
                chk(mem[addr[9:2]] == regsnap[20 + k], {"R2 push slot ", tag},
                    mem[addr[9:2]], regsnap[20 + k]);
            end
        end
        chk(sp_o == sp - 32'(4 * n) - 32'(4 * frame), {"R3 final sp ", tag},
            sp_o, sp - 32'(4 * n) - 32'(4 * frame));
        chk(cyc == n * (w + 1) + 1, {"R6 cycle count ", tag}, 32'(cyc), 32'(n * (w + 1) + 1));
        chk(jump_o == 1'b0, {"R5 no jump on prepare ", tag}, 32'(jump_o), 32'd0);
        after_done(tag);
        chk(acc_cnt - a0 == n, {"R6 access count ", tag}, 32'(acc_cnt - a0), 32'(n));
    endtask

    task automatic dispose_test(input logic [11:0] list, input logic [4:0] frame,
                                input logic [4:0] jreg, input logic [31:0] sp, input int w,
                                input string tag);
        int cyc;
        int a0;
        int n;
        int jx;
        logic [31:0] addr;
        wait_cfg = w;
        memsnap = mem;
        a0 = acc_cnt;
        n = popc(list);
        jx = (jreg != 5'd0) ? 1 : 0;
        run_op(1'b1, list, frame, jreg, sp, 0, cyc);
        addr = sp + 32'(4 * frame);
        for (int k = 11; k >= 0; k--) begin
            if (list[k]) begin
                chk(regs[20 + k] == memsnap[addr[9:2]], {"R4 reload ", tag},
                    regs[20 + k], memsnap[addr[9:2]]);
                addr = addr + 32'd4;
            end
        end
        chk(sp_o == addr, {"R4 final sp ", tag}, sp_o, addr);
        chk(jump_o == (jx == 1), {"R5 jump flag ", tag}, 32'(jump_o), 32'(jx));
        if (jx == 1)
            chk(jump_addr_o == regs[jreg], {"R5 jump target ", tag}, jump_addr_o, regs[jreg]);
        chk(cyc == n * (w + 1) + jx + 1, {"R6 cycle count ", tag}, 32'(cyc), 32'(n * (w + 1) + jx + 1));
        after_done(tag);
        chk(acc_cnt - a0 == n, {"R6 access count ", tag}, 32'(acc_cnt - a0), 32'(n));
    endtask

    task automatic t_reset();
        chk(!busy_o && !done_o && !mem_req_o && !rf_we_o && !jump_o, "R1 reset outputs",
            {27'd0, busy_o, done_o, mem_req_o, rf_we_o, jump_o}, 32'd0);
    endtask

    task automatic t_prepare_basic();
        // R10: op 0 is prepare; r20, r22, r25 selected
        prepare_test(12'h025, 5'd3, 32'h300, 0, 0, "basic");
    endtask

    task automatic t_dispose_basic();
        for (int i = 0; i < 16; i++) mem[125 + i] = 32'hD000_0000 + 32'(i * 17);
        // R10: op 1 is dispose; r21, r24, r31, no jump
        dispose_test(12'h812, 5'd2, 5'd0, 32'h1F4, 0, "basic");
    endtask

    task automatic t_round_trip();
        logic [31:0] orig [32];
        logic [31:0] mid_sp;
        orig = regs;
        prepare_test(12'hFFF, 5'd5, 32'h380, 2, 0, "full waits");
        mid_sp = sp_o;
        for (int r = 20; r < 32; r++) regs[r] = 32'hBAD0_0000 + 32'(r);
        // R7: every access waits two cycles for ready
        dispose_test(12'hFFF, 5'd5, 5'd31, mid_sp, 2, "full waits");
        for (int r = 20; r < 32; r++)
            chk(regs[r] == orig[r], "R4 round trip restore", regs[r], orig[r]);
        chk(sp_o == 32'h380, "R3 round trip sp", sp_o, 32'h380);
        chk(jump_addr_o == orig[31], "R5 jump from reloaded r31", jump_addr_o, orig[31]);
    endtask

    task automatic t_trivial();
        prepare_test(12'h000, 5'd0, 32'h240, 0, 0, "empty");
        prepare_test(12'h000, 5'd7, 32'h240, 0, 0, "frame only");
        dispose_test(12'h000, 5'd0, 5'd5, 32'h240, 0, "jump only");
        dispose_test(12'h000, 5'd4, 5'd0, 32'h240, 0, "frame only");
    endtask

    task automatic t_busy_ignore();
        int a0;
        // R9: start pulse in cycle 2 of a running prepare
        prepare_test(12'h300, 5'd1, 32'h2C0, 1, 2, "busy poke");
        a0 = acc_cnt;
        repeat (3) begin
            @(negedge clk);
            chk(!busy_o && !mem_req_o, "R9 no late start", {30'd0, busy_o, mem_req_o}, 32'd0);
        end
        chk(acc_cnt == a0, "R9 no extra access", 32'(acc_cnt), 32'(a0));
        chk(sp_o == 32'h2C0 - 32'd12, "R9 sp untouched", sp_o, 32'h2C0 - 32'd12);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = (i == 0) ? 32'd0 : 32'hA500_0000 + 32'(i * 32'h0101);
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        rst_n = 1'b0; start_i = 1'b0; op_i = 1'b0; list_i = '0; frame_i = '0; jreg_i = '0; sp_i = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prepare_basic();
        t_dispose_basic();
        t_round_trip();
        t_trivial();
        t_busy_ignore();
        summary();
    end

endmodule